// File: doc/BRIEF.md
# Luma Downsampler for Chroma Prediction

This block turns the reconstructed luma samples of one block into the scaled luma buffer used by a chroma-from-luma predictor. Luma arrives one full row per beat. Each output entry is formed from one, two or four luma samples, depending on the chroma format chosen when the block starts. The sum is then shifted left so that every format ends up on the same times-eight scale. That scale gives three fractional bits relative to one luma sample.

Software or an upstream sequencer does four things in order. It pulses `start_i` with the format, the output width code and the luma row count. It then streams the rows, with idle cycles allowed between them. The block writes each finished output row as one wide, lane-masked write into an external row-organised buffer whose line pitch is fixed at 32 entries. A one-cycle done pulse marks the end of the block.

Samples are unsigned with up to 12 bits. Narrower content, such as 8-bit video, is presented zero-extended.

Top module: `cfl_luma_ss`

## Requirements
- R1: With format code 0 (both directions halved), output row k, entry j equals 2 × (sum of samples 2j and 2j+1 from luma rows 2k and 2k+1).
- R2: With format code 1 (horizontal halving only), output row k, entry j equals 4 × (sample 2j + sample 2j+1 of luma row k).
- R3: With format code 2 (no subsampling), entry j of output row k equals 8 × sample j of luma row k. Format code 3 behaves exactly like code 2.
- R4: Output row k is written at buffer address 32·k. Format 0 writes height/2 rows, and the other formats write one row per luma row.
- R5: Width code w (0..3) selects 4<<w output entries. Write-mask bits 0..(4<<w)-1 are set and all higher bits are clear, and unselected lanes carry zero data. Samples that the selected width does not need have no effect on the result.
- R6: Full-scale 12-bit input (all samples 4095) yields 32760 in every format, with no overflow.
- R7: `done_o` is high for exactly one cycle. That cycle is the one right after the cycle in which the last row write is presented, and `busy_o` is low during it. Every write occurs while `busy_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The block in progress keeps its format, width and row count.
- R9: A row beat presented while the block is idle produces no write. Idle cycles between row beats of a running block do not change the result.
- R10: After reset, `busy_o`, `done_o` and `wr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block, sampled when idle |
| fmt_i | input | 2 | Format code: 0 both-halved, 1 horizontal-halved, 2/3 full |
| wcode_i | input | 2 | Output width code, width = 4<<wcode_i entries |
| height_i | input | 7 | Luma row count of the block (1..64, even for format 0) |
| row_valid_i | input | 1 | A luma row is present on row_data_i |
| row_data_i | input | 768 | 64 samples, sample i at bits [12i +: 12] |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle end-of-block pulse |
| wr_en_o | output | 1 | Row write strobe |
| wr_addr_o | output | 11 | Buffer address of the row's entry 0 |
| wr_mask_o | output | 32 | Per-entry write enable |
| wr_data_o | output | 512 | 32 entries, entry j at bits [16j +: 16] |

## Verification
The hardest situation to reach from the ports is a second start arriving in the middle of a running block. It is hardest when that start carries a different format, width and row count in the same cycle as a valid row beat. The directed scenario raises `start_i` with conflicting settings during a row beat. It then checks that the write count, the mask and every entry still follow the original settings. Other scenarios insert idle cycles between the two rows of a vertically combined pair. They also fill the unused input lanes with nonzero patterns, so that pairing and lane selection are exercised under stalls.

// File: rtl/cfl_ss_pkg.sv
package cfl_ss_pkg;
  typedef enum logic [1:0] {
    FMT_HV   = 2'd0,
    FMT_H    = 2'd1,
    FMT_FULL = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;
endpackage

// File: rtl/cfl_ss_lane.sv
module cfl_ss_lane
  import cfl_ss_pkg::*;
#(
  parameter int SW = 12,
  parameter int EW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          store_i,
  input  fmt_e          fmt_i,
  input  logic [SW-1:0] s_even_i,
  input  logic [SW-1:0] s_odd_i,
  input  logic [SW-1:0] s_own_i,
  output logic [EW-1:0] val_o
);
  logic [SW:0]   hsum;
  logic [SW:0]   pair_q;
  logic [SW+1:0] quad;

  assign hsum = {1'b0, s_even_i} + {1'b0, s_odd_i};
  assign quad = {1'b0, hsum} + {1'b0, pair_q};

  // upper row of a vertical pair, kept as its horizontal sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pair_q <= '0;
    else if (store_i) pair_q <= hsum;
  end

  always_comb begin
    unique case (fmt_i)
      FMT_HV:  val_o = EW'({quad, 1'b0});
      FMT_H:   val_o = EW'({hsum, 2'b00});
      default: val_o = EW'({s_own_i, 3'b000});
    endcase
  end
endmodule

// File: rtl/cfl_ss_ctrl.sv
module cfl_ss_ctrl
  import cfl_ss_pkg::*;
#(
  parameter int ROW_CW = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  fmt_e              fmt_i,
  input  logic [1:0]        wcode_i,
  input  logic [ROW_CW-1:0] height_i,
  input  logic              row_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output fmt_e              fmt_o,
  output logic [1:0]        wcode_o,
  output logic              store_o,
  output logic              emit_o,
  output logic [ROW_CW-1:0] out_row_o
);
  logic              busy_q, done_q, last_q;
  logic [ROW_CW-1:0] in_cnt_q, height_q;
  fmt_e              fmt_q;
  logic [1:0]        wcode_q;
  logic              take, pair_mode, final_beat;

  assign pair_mode  = (fmt_q == FMT_HV);
  assign take       = busy_q & row_valid_i & ~last_q;
  assign final_beat = take & (in_cnt_q == height_q - ROW_CW'(1));
  assign store_o    = take & pair_mode & ~in_cnt_q[0];
  assign emit_o     = take & (~pair_mode | in_cnt_q[0]);
  assign out_row_o  = pair_mode ? (in_cnt_q >> 1) : in_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      last_q   <= 1'b0;
      in_cnt_q <= '0;
      height_q <= '0;
      fmt_q    <= FMT_HV;
      wcode_q  <= '0;
    end else begin
      done_q <= last_q;
      if (!busy_q && start_i) begin
        busy_q   <= 1'b1;
        last_q   <= 1'b0;
        in_cnt_q <= '0;
        height_q <= height_i;
        fmt_q    <= fmt_i;
        wcode_q  <= wcode_i;
      end else if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else if (take) begin
        in_cnt_q <= in_cnt_q + ROW_CW'(1);
        if (final_beat) last_q <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign fmt_o   = fmt_q;
  assign wcode_o = wcode_q;
endmodule

// File: rtl/cfl_luma_ss.sv
module cfl_luma_ss
  import cfl_ss_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int OUT_LANES  = 32,
  parameter int ENTRY_W    = 16,
  parameter int MAX_ROWS   = 64,
  parameter int LINE_PITCH = 32,
  localparam int IN_LANES  = 2 * OUT_LANES,
  localparam int ROW_CW    = $clog2(MAX_ROWS + 1),
  localparam int ROW_AW    = $clog2(MAX_ROWS),
  localparam int PITCH_W   = $clog2(LINE_PITCH),
  localparam int ADDR_W    = ROW_AW + PITCH_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [1:0]                    fmt_i,
  input  logic [1:0]                    wcode_i,
  input  logic [ROW_CW-1:0]             height_i,
  input  logic                          row_valid_i,
  input  logic [IN_LANES*SAMPLE_W-1:0]  row_data_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          wr_en_o,
  output logic [ADDR_W-1:0]             wr_addr_o,
  output logic [OUT_LANES-1:0]          wr_mask_o,
  output logic [OUT_LANES*ENTRY_W-1:0]  wr_data_o
);
  fmt_e                         fmt_q;
  logic [1:0]                   wcode_q;
  logic                         store, emit;
  logic [ROW_CW-1:0]            out_row;
  logic [OUT_LANES-1:0]         lane_en;
  logic [OUT_LANES*ENTRY_W-1:0] nxt_data;

  cfl_ss_ctrl #(.ROW_CW(ROW_CW)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .fmt_i      (fmt_e'(fmt_i)),
    .wcode_i    (wcode_i),
    .height_i   (height_i),
    .row_valid_i(row_valid_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fmt_o      (fmt_q),
    .wcode_o    (wcode_q),
    .store_o    (store),
    .emit_o     (emit),
    .out_row_o  (out_row)
  );

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_lane
    logic [ENTRY_W-1:0] val;
    cfl_ss_lane #(.SW(SAMPLE_W), .EW(ENTRY_W)) lane_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .store_i (store),
      .fmt_i   (fmt_q),
      .s_even_i(row_data_i[(2*g)*SAMPLE_W +: SAMPLE_W]),
      .s_odd_i (row_data_i[(2*g+1)*SAMPLE_W +: SAMPLE_W]),
      .s_own_i (row_data_i[g*SAMPLE_W +: SAMPLE_W]),
      .val_o   (val)
    );
    assign lane_en[g] = (32'(g) < (32'd4 << wcode_q));
    assign nxt_data[g*ENTRY_W +: ENTRY_W] = lane_en[g] ? val : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_mask_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= emit;
      if (emit) begin
        wr_addr_o <= {out_row[ROW_AW-1:0], PITCH_W'(0)};
        wr_mask_o <= lane_en;
        wr_data_o <= nxt_data;
      end
    end
  end
endmodule

// File: rtl/cfl_luma_ss_chk.sv
module cfl_luma_ss_chk #(
  parameter int OUT_LANES = 32,
  parameter int ENTRY_W   = 16,
  parameter int ADDR_W    = 11,
  parameter int PITCH_W   = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         busy_o,
  input logic                         done_o,
  input logic                         wr_en_o,
  input logic [ADDR_W-1:0]            wr_addr_o,
  input logic [OUT_LANES-1:0]         wr_mask_o,
  input logic [OUT_LANES*ENTRY_W-1:0] wr_data_o
);
  function automatic logic [OUT_LANES*ENTRY_W-1:0] lsb_pat();
    logic [OUT_LANES*ENTRY_W-1:0] p;
    p = '0;
    for (int k = 0; k < OUT_LANES; k++) p[k*ENTRY_W] = 1'b1;
    return p;
  endfunction
  localparam logic [OUT_LANES*ENTRY_W-1:0] LSB_PAT = lsb_pat();

  p_even_entries_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ((wr_data_o & LSB_PAT) == '0));

  p_row_pitch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[PITCH_W-1:0] == '0));

  p_mask_prefix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (((wr_mask_o & (wr_mask_o + 1'b1)) == '0) && ($countones(wr_mask_o) >= 4)));

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_zero
    p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_o && !wr_mask_o[g]) |-> (wr_data_o[g*ENTRY_W +: ENTRY_W] == '0));
  end

  p_write_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_busy_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !wr_en_o);
endmodule

bind cfl_luma_ss cfl_luma_ss_chk #(
  .OUT_LANES(OUT_LANES),
  .ENTRY_W  (ENTRY_W),
  .ADDR_W   (ADDR_W),
  .PITCH_W  (PITCH_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .wr_en_o  (wr_en_o),
  .wr_addr_o(wr_addr_o),
  .wr_mask_o(wr_mask_o),
  .wr_data_o(wr_data_o)
);

// File: tb/cfl_luma_ss_tb_top.sv
module cfl_luma_ss_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   fmt_i = '0;
  logic [1:0]   wcode_i = '0;
  logic [6:0]   height_i = '0;
  logic         row_valid_i = 1'b0;
  logic [767:0] row_data_i = '0;
  logic         busy_o, done_o, wr_en_o;
  logic [10:0]  wr_addr_o;
  logic [31:0]  wr_mask_o;
  logic [511:0] wr_data_o;

  int errors = 0;
  int checks = 0;
  int wcount = 0;
  int mem [2048];
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  cfl_luma_ss dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fmt_i(fmt_i),
    .wcode_i(wcode_i), .height_i(height_i), .row_valid_i(row_valid_i),
    .row_data_i(row_data_i), .busy_o(busy_o), .done_o(done_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_mask_o(wr_mask_o),
    .wr_data_o(wr_data_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni && wr_en_o) begin
      wcount++;
      for (int j = 0; j < 32; j++)
        if (wr_mask_o[j]) mem[int'(wr_addr_o) + j] = int'(wr_data_o[j*16 +: 16]);
    end
  end

  function automatic int samp(int seed, int r, int i);
    if (seed == 0) return 4095;
    return ((r * 67 + i * 29 + seed * 13) ^ (i << 3)) & 12'hFFF;
  endfunction

  function automatic int exp_val(int fmt, int seed, int k, int j);
    case (fmt)
      0: return 2 * (samp(seed, 2*k, 2*j) + samp(seed, 2*k, 2*j+1) +
                     samp(seed, 2*k+1, 2*j) + samp(seed, 2*k+1, 2*j+1));
      1: return 4 * (samp(seed, k, 2*j) + samp(seed, k, 2*j+1));
      default: return 8 * samp(seed, k, j);
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic drive_row(int seed, int r);
    for (int i = 0; i < 64; i++) row_data_i[i*12 +: 12] = 12'(samp(seed, r, i));
    row_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    row_valid_i = 1'b0;
  endtask

  // one block: start, stream rows, check timing, rows and write count
  task automatic run_block(int fmt, int wc, int height, int seed, bit gaps,
                           bit poke, string tag);
    int width, nrows, w0, act, exp;
    bit ok;
    width = 4 << wc;
    nrows = (fmt == 0) ? height / 2 : height;
    for (int a = 0; a < 2048; a++) mem[a] = -1;
    w0 = wcount;
    @(negedge clk_i);
    start_i = 1'b1; fmt_i = 2'(fmt); wcode_i = 2'(wc); height_i = 7'(height);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int r = 0; r < height; r++) begin
      if (gaps && (r % 3 == 1)) begin
        row_data_i = {24{32'hA5A5_5A5A}};
        @(posedge clk_i);
        @(negedge clk_i);
      end
      if (poke && r == 2) begin
        start_i = 1'b1; fmt_i = 2'd2; wcode_i = 2'd3; height_i = 7'd2;
      end
      drive_row(seed, r);
      start_i = 1'b0;
    end
    chk(wr_en_o && !done_o, "R7", "last write before done", int'(done_o), 0);
    @(negedge clk_i);
    chk(done_o && !busy_o, "R7", "done pulse with busy low", int'(done_o), 1);
    @(negedge clk_i);
    chk(!done_o, "R7", "done lasts one cycle", int'(done_o), 0);
    chk(wcount - w0 == nrows, {"R4 ", tag}, "row write count", wcount - w0, nrows);
    for (int k = 0; k < nrows; k++) begin
      ok = 1; act = 0; exp = 0;
      for (int j = 0; j < 32; j++) begin
        int e;
        e = (j < width) ? exp_val(fmt, seed, k, j) : -1;
        if (mem[k*32 + j] != e && ok) begin
          ok = 0; act = mem[k*32 + j]; exp = e;
        end
      end
      chk(ok, {"R4 R5 ", tag}, $sformatf("row %0d entries", k), act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(!busy_o && !done_o && !wr_en_o, "R10", "outputs in reset",
        int'({busy_o, done_o, wr_en_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !wr_en_o, "R10", "outputs after reset",
        int'({busy_o, done_o, wr_en_o}), 0);

    // R9: beats while idle are dropped
    begin
      int w0;
      w0 = wcount;
      for (int r = 0; r < 3; r++) drive_row(7, r);
      @(negedge clk_i);
      chk(wcount == w0 && !busy_o, "R9", "idle row beats write nothing", wcount - w0, 0);
    end

    run_block(0, 0, 8, 1, 0, 0, "R1");
    run_block(0, 3, 64, 2, 1, 0, "R1 R9");
    run_block(1, 1, 6, 3, 0, 1, "R2 R8");
    run_block(1, 2, 16, 4, 1, 0, "R2");
    run_block(2, 3, 32, 5, 1, 0, "R3");
    run_block(3, 0, 4, 6, 0, 0, "R3");
    run_block(2, 1, 3, 8, 0, 0, "R3");
    run_block(0, 3, 4, 0, 0, 0, "R6 R1");
    run_block(1, 3, 2, 0, 0, 0, "R6 R2");
    run_block(2, 3, 2, 0, 0, 0, "R6 R3");
    finish_run();
  end
endmodule